// File: doc/BRIEF.md
# Fractional Master-Clock Strobe Generator

The block produces a master-clock strobe for an audio path from one of four clock-enable sources. Everything runs on one system clock: each source is a single-cycle enable pulse. A two-bit select picks the source. When the divider is off, the output follows the picked source one cycle later. When the divider is on, an accumulator turns the source pulses into output strobes whose long-run rate is the source rate times (FRACT+1)/(DIVIDE+1).

The ratio comes from a write port that carries an 8-bit numerator field and a 12-bit denominator field. A configuration write sets the select and the divider on/off control. A new ratio written while the divider runs is held as pending, and a busy flag is raised. That ratio takes over at the next accumulator wrap. Until then, more ratio writes are dropped. This keeps a running clock from picking up a half-applied ratio. The programmed ratio can be read back on a parallel port.

Top module: `mclk_frac_div`

## Requirements
- R1: After reset, mclkTick, updBusy, selRd and ratioRd are all zero, and the divider is off.
- R2: With the divider off, mclkTick in each cycle equals srcTick[selRd] from the previous cycle.
- R3: With the divider on, each pulse of the selected source adds FRACT+1 to an accumulator that starts at zero. When the sum reaches DIVIDE+1 or more, DIVIDE+1 is taken off and mclkTick is high in the next cycle. Pulses on sources that are not selected have no effect.
- R4: A configuration write always updates the divider on/off control. It changes selRd only if the divider was off when the write was made. Otherwise the select keeps its old value.
- R5: A ratio write made while the divider is off takes effect at once and leaves updBusy low.
- R6: A ratio write made while the divider is on and updBusy is low raises updBusy in the next cycle. Read-back shows the new ratio.
- R7: While updBusy is high, ratio writes are ignored and ratioRd keeps its value.
- R8: A pending ratio takes effect at the next accumulator wrap. The wrap still gives its strobe, the accumulator restarts at zero, and updBusy falls at that same edge.
- R9: A ratio write with FRACT greater than DIVIDE is rejected, and the old ratio stays in place.
- R10: ratioRd holds FRACT in bits 19:12 and DIVIDE in bits 11:0. All other bits read as zero.
- R11: If the divider is turned off while a ratio is pending, the pending ratio takes effect and updBusy falls one cycle after the divider goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcTick | input | 4 | Clock-enable pulses of the four sources |
| ratioWr | input | 1 | Ratio write strobe |
| ratioFract | input | 8 | Numerator field (FRACT) |
| ratioDiv | input | 12 | Denominator field (DIVIDE) |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Requested source select |
| cfgDivOn | input | 1 | Divider on (1) or bypass (0) |
| mclkTick | output | 1 | Output master-clock strobe |
| updBusy | output | 1 | Pending-ratio flag |
| selRd | output | 2 | Current source select |
| ratioRd | output | 32 | Read-back of the programmed ratio |

## Verification
The assertions assume that every write is a pulse, sampled on a rising edge, with steady data fields. They also assume that srcTick bits are plain enables with no relation to one another, so a pulse can land on any cycle. The stimulus drives every input on the falling edge and holds it for whole cycles. It always starts a ratio run from a bypass state, so the accumulator begins at zero. Pulses on the sources that are not selected are put in the gap cycles between selected pulses. That way any leak from an unselected source would change the strobe count.

// File: rtl/mclk_frac_div_pkg.sv
package mclk_frac_div_pkg;
  // control strobes handed from control to datapath
  typedef struct packed {
    logic       divOn;       // divided mode active
    logic       applyArmed;  // a pending ratio waits for the next wrap
    logic [1:0] srcSel;      // chosen source
  } fdCtl_t;
endpackage

// File: rtl/mclk_frac_div_ctrl.sv
module mclk_frac_div_ctrl
  import mclk_frac_div_pkg::*;
#(
  parameter int FW = 8,
  parameter int DW = 12,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ratioWr,
  input  logic [FW-1:0] ratioFract,
  input  logic [DW-1:0] ratioDiv,
  input  logic          cfgWr,
  input  logic [SW-1:0] cfgSel,
  input  logic          cfgDivOn,
  input  logic          wrapEv,
  output fdCtl_t        ctl,
  output logic [FW-1:0] actFract,
  output logic [DW-1:0] actDiv,
  output logic [FW-1:0] pendFract,
  output logic [DW-1:0] pendDiv,
  output logic          updBusy
);
  logic          divOn;
  logic [SW-1:0] sel;
  logic          ratioOk;
  logic          ratioTake;

  assign ratioOk   = DW'(ratioFract) <= ratioDiv;
  assign ratioTake = ratioWr && ratioOk && !updBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divOn <= 1'b0;
      sel   <= '0;
    end else if (cfgWr) begin
      divOn <= cfgDivOn;
      if (!divOn) sel <= cfgSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFract <= '0;
      pendDiv   <= '0;
      actFract  <= '0;
      actDiv    <= '0;
      updBusy   <= 1'b0;
    end else if (ratioTake) begin
      pendFract <= ratioFract;
      pendDiv   <= ratioDiv;
      if (divOn) begin
        updBusy <= 1'b1;
      end else begin
        actFract <= ratioFract;
        actDiv   <= ratioDiv;
      end
    end else if (updBusy && (!divOn || wrapEv)) begin
      actFract <= pendFract;
      actDiv   <= pendDiv;
      updBusy  <= 1'b0;
    end
  end

  always_comb begin
    ctl.divOn      = divOn;
    ctl.applyArmed = updBusy;
    ctl.srcSel     = sel;
  end
endmodule

// File: rtl/mclk_frac_div_dp.sv
module mclk_frac_div_dp
  import mclk_frac_div_pkg::*;
#(
  parameter int FW   = 8,
  parameter int DW   = 12,
  parameter int NSRC = 4,
  parameter int SW   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  fdCtl_t          ctl,
  input  logic [NSRC-1:0] srcTick,
  input  logic [FW-1:0]   actFract,
  input  logic [DW-1:0]   actDiv,
  output logic            wrapEv,
  output logic            mclkTick
);
  localparam int AW = DW + 2;

  logic [NSRC-1:0] selHit;
  logic            tickSel;
  logic [AW-1:0]   acc;
  logic [AW-1:0]   sum;
  logic [AW-1:0]   period;

  for (genvar g = 0; g < NSRC; g++) begin : g_srcSel
    assign selHit[g] = srcTick[g] && (ctl.srcSel == SW'(g));
  end

  assign tickSel = |selHit;
  assign sum     = acc + AW'(actFract) + AW'(1);
  assign period  = AW'(actDiv) + AW'(1);
  assign wrapEv  = ctl.divOn && tickSel && (sum >= period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (!ctl.divOn) begin
      acc <= '0;
    end else if (tickSel) begin
      if (wrapEv) acc <= ctl.applyArmed ? '0 : sum - period;
      else        acc <= sum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mclkTick <= 1'b0;
    else       mclkTick <= ctl.divOn ? wrapEv : tickSel;
  end
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
  import mclk_frac_div_pkg::*;
#(
  parameter int FW   = 8,
  parameter int DW   = 12,
  parameter int NSRC = 4,
  parameter int RDW  = 32,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcTick,
  input  logic            ratioWr,
  input  logic [FW-1:0]   ratioFract,
  input  logic [DW-1:0]   ratioDiv,
  input  logic            cfgWr,
  input  logic [SW-1:0]   cfgSel,
  input  logic            cfgDivOn,
  output logic            mclkTick,
  output logic            updBusy,
  output logic [SW-1:0]   selRd,
  output logic [RDW-1:0]  ratioRd
);
  fdCtl_t        ctl;
  logic          wrapEv;
  logic          divOnQ;
  logic [FW-1:0] actFract;
  logic [DW-1:0] actDiv;
  logic [FW-1:0] pendFract;
  logic [DW-1:0] pendDiv;

  mclk_frac_div_ctrl #(.FW(FW), .DW(DW), .SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ratioWr(ratioWr), .ratioFract(ratioFract), .ratioDiv(ratioDiv),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgDivOn(cfgDivOn),
    .wrapEv(wrapEv), .ctl(ctl),
    .actFract(actFract), .actDiv(actDiv),
    .pendFract(pendFract), .pendDiv(pendDiv),
    .updBusy(updBusy)
  );

  mclk_frac_div_dp #(.FW(FW), .DW(DW), .NSRC(NSRC), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcTick(srcTick),
    .actFract(actFract), .actDiv(actDiv),
    .wrapEv(wrapEv), .mclkTick(mclkTick)
  );

  assign divOnQ  = ctl.divOn;
  assign selRd   = ctl.srcSel;
  assign ratioRd = RDW'({pendFract, pendDiv});
endmodule

// File: rtl/mclk_frac_div_chk.sv
module mclk_frac_div_chk #(
  parameter int FW   = 8,
  parameter int DW   = 12,
  parameter int NSRC = 4,
  parameter int RDW  = 32,
  parameter int SW   = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] srcTick,
  input logic            ratioWr,
  input logic [FW-1:0]   ratioFract,
  input logic [DW-1:0]   ratioDiv,
  input logic            cfgWr,
  input logic            divOn,
  input logic            mclkTick,
  input logic            updBusy,
  input logic [SW-1:0]   selRd,
  input logic [RDW-1:0]  ratioRd
);
  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !divOn |=> (mclkTick == $past(srcTick[selRd]))); // R2
  AST_NO_TICK_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    divOn && !srcTick[selRd] |=> !mclkTick); // R3
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    divOn && cfgWr |=> $stable(selRd)); // R4
  AST_OFF_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !divOn |=> !updBusy); // R5
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rstN)
    divOn && !updBusy && ratioWr && (DW'(ratioFract) <= ratioDiv) |=> updBusy); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    updBusy && ratioWr |=> $stable(ratioRd)); // R7
  AST_APPLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updBusy) && $past(divOn) |-> mclkTick); // R8
  AST_BAD_RATIO: assert property (@(posedge clk) disable iff (!rstN)
    ratioWr && (DW'(ratioFract) > ratioDiv) |=> $stable(ratioRd)); // R9
endmodule

bind mclk_frac_div mclk_frac_div_chk #(
  .FW(FW), .DW(DW), .NSRC(NSRC), .RDW(RDW), .SW(SW)
) u_chk (
  .clk(clk), .rstN(rstN), .srcTick(srcTick),
  .ratioWr(ratioWr), .ratioFract(ratioFract), .ratioDiv(ratioDiv),
  .cfgWr(cfgWr), .divOn(divOnQ), .mclkTick(mclkTick),
  .updBusy(updBusy), .selRd(selRd), .ratioRd(ratioRd)
);

// File: tb/mclk_frac_div_tb.sv
`timescale 1ns/1ps
module mclk_frac_div_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcTick = '0;
  logic        ratioWr = 1'b0;
  logic [7:0]  ratioFract = '0;
  logic [11:0] ratioDiv = '0;
  logic        cfgWr = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic        cfgDivOn = 1'b0;
  logic        mclkTick, updBusy;
  logic [1:0]  selRd;
  logic [31:0] ratioRd;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mclk_frac_div u_dut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick),
    .ratioWr(ratioWr), .ratioFract(ratioFract), .ratioDiv(ratioDiv),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgDivOn(cfgDivOn),
    .mclkTick(mclkTick), .updBusy(updBusy), .selRd(selRd), .ratioRd(ratioRd)
  );

  // fract(8) div(12) sel(2) ticks(8) expected strobes(8)
  localparam logic [37:0] VECS [0:6] = '{
    {8'd0, 12'd0,  2'd0, 8'd10, 8'd10},
    {8'd0, 12'd1,  2'd1, 8'd10, 8'd5},
    {8'd1, 12'd2,  2'd2, 8'd9,  8'd6},
    {8'd2, 12'd4,  2'd3, 8'd10, 8'd6},
    {8'd0, 12'd3,  2'd0, 8'd8,  8'd2},
    {8'd4, 12'd4,  2'd1, 8'd6,  8'd6},
    {8'd7, 12'd99, 2'd2, 8'd25, 8'd2}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrRatio(logic [7:0] f, logic [11:0] d);
    @(negedge clk); ratioWr = 1'b1; ratioFract = f; ratioDiv = d;
    @(negedge clk); ratioWr = 1'b0;
  endtask

  task automatic wrCfg(logic [1:0] s, logic on);
    @(negedge clk); cfgWr = 1'b1; cfgSel = s; cfgDivOn = on;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  // one selected pulse, then a gap cycle carrying the other sources
  task automatic pulse(logic [1:0] s, output logic strobeA, output logic strobeB);
    @(negedge clk); srcTick = 4'b1 << s;
    @(negedge clk); strobeA = mclkTick; srcTick = ~(4'b1 << s);
    @(negedge clk); strobeB = mclkTick; srcTick = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic a, b;
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 mclkTick", 32'(mclkTick), 0);
    check("R1 updBusy", 32'(updBusy), 0);
    check("R1 ratioRd", ratioRd, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 selRd", 32'(selRd), 0);

    // ratio table, each run from bypass so the accumulator starts at zero (R3)
    for (int i = 0; i < 7; i++) begin
      logic [7:0]  f;
      logic [11:0] d;
      logic [1:0]  s;
      logic [7:0]  n, e;
      {f, d, s, n, e} = VECS[i];
      wrCfg(s, 1'b0);
      wrRatio(f, d);
      wrCfg(s, 1'b1);
      cnt = 0;
      for (int k = 0; k < n; k++) begin
        pulse(s, a, b);
        cnt += int'(a) + int'(b);
      end
      check("R3 strobe count", 32'(cnt), 32'(e));
      wrCfg(s, 1'b0);
    end

    // R2 bypass follows the selected source only
    wrCfg(2'd2, 1'b0);
    @(negedge clk); srcTick = 4'b0100;
    @(negedge clk); check("R2 bypass selected", 32'(mclkTick), 1); srcTick = 4'b1011;
    @(negedge clk); check("R2 bypass others", 32'(mclkTick), 0); srcTick = '0;

    // R4 select locked while enabled
    wrCfg(2'd1, 1'b1);
    wrCfg(2'd3, 1'b1);
    check("R4 sel kept", 32'(selRd), 1);
    wrCfg(2'd3, 1'b0);
    check("R4 sel kept on disable", 32'(selRd), 1);
    @(negedge clk); srcTick = 4'b0010;
    @(negedge clk); check("R4 bypass old sel", 32'(mclkTick), 1); srcTick = 4'b1000;
    @(negedge clk); check("R4 bypass new sel ignored", 32'(mclkTick), 0); srcTick = '0;

    // R5 / R10 / R9
    wrRatio(8'd3, 12'd7);
    check("R5 no busy", 32'(updBusy), 0);
    check("R10 layout", ratioRd, 32'h0000_3007);
    wrRatio(8'd9, 12'd5);
    check("R9 rejected", ratioRd, 32'h0000_3007);
    wrRatio(8'hAB, 12'hCDE);
    check("R10 full fields", ratioRd, 32'h000A_BCDE);

    // R6 / R7 / R8
    wrCfg(2'd0, 1'b0);
    wrRatio(8'd0, 12'd3);
    wrCfg(2'd0, 1'b1);
    wrRatio(8'd1, 12'd1);
    check("R6 busy set", 32'(updBusy), 1);
    check("R6 readback new", ratioRd, 32'h0000_1001);
    wrRatio(8'd0, 12'd0);
    check("R7 write ignored", ratioRd, 32'h0000_1001);
    for (int k = 1; k <= 3; k++) begin
      pulse(2'd0, a, b);
      check("R8 no early strobe", 32'(a | b), 0);
      check("R8 busy held", 32'(updBusy), 1);
    end
    pulse(2'd0, a, b);
    check("R8 wrap strobe", 32'(a), 1);
    check("R8 busy cleared", 32'(updBusy), 0);
    pulse(2'd0, a, b);
    check("R8 new ratio active", 32'(a), 1);

    // R11 disable while pending
    wrRatio(8'd2, 12'd5);
    check("R11 busy before", 32'(updBusy), 1);
    wrCfg(2'd0, 1'b0);
    @(negedge clk);
    check("R11 busy cleared", 32'(updBusy), 0);
    check("R11 readback", ratioRd, 32'h0000_2005);
    wrRatio(8'd3, 12'd3);
    check("R11 write accepted after", ratioRd, 32'h0000_3003);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule